// File: doc/BRIEF.md
# Destination Route Cache with Table Bank Swap

This block holds recently used forwarding routes so that most datagrams can be forwarded without a full table search. A lookup presents a 32-bit IPv4 destination. The destination is folded by XOR into a line index. The line is a hit only when it is valid and its stored 32-bit tag equals the destination exactly. A hit returns the 64-bit route on the cycle after the lookup is accepted. A miss makes the block stop taking lookups and hold the missing destination for a slow-path engine. That engine searches the active bank of the double-banked forwarding table and returns the route through a refill strobe. The refill writes the line and releases the block.

A management agent loads new tables into the idle bank. It then pulses a swap request. The swap takes effect on the first cycle that has no lookup response in flight. On that cycle the active-bank bit toggles and every line is invalidated at once. A refill still pending at that moment belongs to the old bank, so it is dropped and never written into the flushed cache.

Top module: `route_cache`

## Requirements
- R1: After reset `lk_ready` is 1, `rsp_valid` is 0, `miss_busy` is 0, `bank_sel` is 0, and every line is invalid, so the first lookup of any destination misses.
- R2: The line index is the XOR fold of the destination. Index bit i is the XOR of all destination bits j with j mod IDX_W equal to i. Two destinations with the same index share one line, and the later fill evicts the earlier one.
- R3: A lookup accepted in cycle T (`lk_valid` and `lk_ready` high at the edge) gives `rsp_valid`=1 in cycle T+1. `rsp_hit` is 1 only if the line is valid and its tag equals the destination. On a hit, `rsp_route` is the stored route.
- R4: After a miss response, `miss_busy` is 1 from the next cycle. `miss_dest` holds the missing destination, and `lk_ready` stays 0 until a refill or a swap ends the miss.
- R5: `refill_valid` while `miss_busy` is 1 writes the line of `miss_dest` with tag `miss_dest` and route `refill_route`, and clears `miss_busy` on the next cycle. `refill_valid` while `miss_busy` is 0 has no effect.
- R6: A swap request is carried out on the first cycle with no response in flight. On that cycle `bank_sel` toggles and all lines become invalid.
- R7: A swap carried out while `miss_busy` is 1 clears `miss_busy`. A refill for the abandoned miss is ignored, and the line stays invalid.
- R8: `lk_ready` is 0 while `swap_req` is high or a swap is waiting to be carried out.
- R9: Hits can be accepted on consecutive cycles with `lk_ready` staying 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_dest | input | 32 | Destination address of the lookup |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Result is a hit |
| rsp_route | output | 64 | Cached route on a hit |
| miss_busy | output | 1 | A miss waits for a refill |
| miss_dest | output | 32 | Destination the slow path must resolve |
| refill_valid | input | 1 | Refill strobe from the slow path |
| refill_route | input | 64 | Route supplied by the refill |
| swap_req | input | 1 | Management request to swap table banks |
| bank_sel | output | 1 | Active forwarding-table bank |

## Verification
The bench builds pairs of destinations that differ in two bits folding onto the same index bit. A design that hashed wrongly or compared only part of the tag would report a false hit on the partner. It asks for a swap while a miss is pending and then drives the stale refill. A design that wrote the refill after the flush would give a hit, or old-bank data, on the next lookup. It also drives a refill with no miss outstanding and asks for swaps while a hit response is still in flight. A design that let the stray refill overwrite a line, or that flushed before the response left, would return a wrong route or a wrong bank.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int ADDR_W  = 32;
  localparam int ROUTE_W = 64;
  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [ROUTE_W-1:0] route_t;
endpackage

// File: rtl/rc_hash.sv
module rc_hash #(
  parameter int IDX_W = 6
) (
  input  rc_pkg::addr_t     dest,
  output logic [IDX_W-1:0]  idx
);
  // XOR fold: destination bit j lands on index bit j mod IDX_W
  function automatic logic [IDX_W-1:0] fold(input rc_pkg::addr_t a);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int j = 0; j < rc_pkg::ADDR_W; j++) begin
      r[j % IDX_W] = r[j % IDX_W] ^ a[j];
    end
    return r;
  endfunction

  assign idx = fold(dest);
endmodule

// File: rtl/rc_store.sv
module rc_store #(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output rc_pkg::addr_t     rd_tag,
  output rc_pkg::route_t    rd_route,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  rc_pkg::addr_t     wr_tag,
  input  rc_pkg::route_t    wr_route,
  input  logic              flush,
  output logic              any_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  rc_pkg::addr_t    tag_q   [LINES];
  rc_pkg::route_t   route_q [LINES];

  // valid bits: flush wins over a same-cycle write
  always_ff @(posedge clk) begin
    if (!rst_n || flush) valid_q <= '0;
    else if (wr_en)      valid_q[wr_idx] <= 1'b1;
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
        if (wr_en && !flush && wr_idx == IDX_W'(g)) begin
          tag_q[g]   <= wr_tag;
          route_q[g] <= wr_route;
        end
      end
    end
  endgenerate

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_route  = route_q[rd_idx];
  assign any_valid = |valid_q;
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  rc_pkg::addr_t lk_dest,
  output logic          lk_ready,
  input  logic          line_match,
  input  logic          refill_valid,
  input  logic          swap_req,
  output logic          s1_valid,
  output rc_pkg::addr_t s1_dest,
  output logic          s1_hit,
  output logic          miss_busy,
  output rc_pkg::addr_t miss_dest,
  output logic          fill_we,
  output logic          swap_fire,
  output logic          bank_sel
);
  logic swap_pend;
  logic s1_miss;
  logic accept;

  assign s1_hit    = s1_valid && line_match;
  assign s1_miss   = s1_valid && !line_match;
  assign lk_ready  = !miss_busy && !swap_pend && !swap_req && !s1_miss;
  assign accept    = lk_valid && lk_ready;
  // a swap waits until no response is in flight
  assign swap_fire = (swap_req || swap_pend) && !s1_valid;
  assign fill_we   = refill_valid && miss_busy && !swap_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_dest   <= '0;
      miss_busy <= 1'b0;
      miss_dest <= '0;
      swap_pend <= 1'b0;
      bank_sel  <= 1'b0;
    end else begin
      s1_valid <= accept;
      if (accept) s1_dest <= lk_dest;

      if (swap_fire)    miss_busy <= 1'b0;
      else if (s1_miss) miss_busy <= 1'b1;
      else if (fill_we) miss_busy <= 1'b0;
      if (s1_miss) miss_dest <= s1_dest;

      swap_pend <= swap_fire ? 1'b0 : (swap_pend || swap_req);
      bank_sel  <= bank_sel ^ swap_fire;
    end
  end
endmodule

// File: rtl/route_cache.sv
module route_cache #(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_dest,
  output logic        lk_ready,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [63:0] rsp_route,
  output logic        miss_busy,
  output logic [31:0] miss_dest,
  input  logic        refill_valid,
  input  logic [63:0] refill_route,
  input  logic        swap_req,
  output logic        bank_sel
);
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             rd_valid, line_match, any_valid;
  rc_pkg::addr_t    rd_tag, s1_dest;
  rc_pkg::route_t   rd_route;
  logic             s1_valid, s1_hit, fill_we, swap_fire;

  rc_hash #(.IDX_W(IDX_W)) u_hash_rd (.dest(s1_dest),   .idx(rd_idx));
  rc_hash #(.IDX_W(IDX_W)) u_hash_wr (.dest(miss_dest), .idx(wr_idx));

  rc_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_route(rd_route),
    .wr_en(fill_we), .wr_idx(wr_idx), .wr_tag(miss_dest), .wr_route(refill_route),
    .flush(swap_fire), .any_valid(any_valid)
  );

  assign line_match = rd_valid && (rd_tag == s1_dest);

  rc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_dest(lk_dest), .lk_ready(lk_ready),
    .line_match(line_match), .refill_valid(refill_valid), .swap_req(swap_req),
    .s1_valid(s1_valid), .s1_dest(s1_dest), .s1_hit(s1_hit),
    .miss_busy(miss_busy), .miss_dest(miss_dest),
    .fill_we(fill_we), .swap_fire(swap_fire), .bank_sel(bank_sel)
  );

  assign rsp_valid = s1_valid;
  assign rsp_hit   = s1_hit;
  assign rsp_route = rd_route;
endmodule

// File: rtl/rc_checker.sv
module rc_checker (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_ready,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic s1_valid,
  input logic swap_fire,
  input logic miss_busy,
  input logic bank_sel,
  input logic any_valid,
  input logic fill_we,
  input logic swap_req
);
  // R3
  rsp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);
  // R4
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |=> (miss_busy && !lk_ready));
  // R6
  swap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |-> !s1_valid);
  // R6
  swap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> (bank_sel != $past(bank_sel)) && !any_valid);
  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_fire |=> $stable(bank_sel));
  // R7
  swap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> !miss_busy);
  // R5
  fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> (miss_busy && !swap_fire));
  // R8
  swap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |-> !lk_ready);
endmodule

bind route_cache rc_checker u_rc_checker (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .s1_valid(s1_valid),
  .swap_fire(swap_fire), .miss_busy(miss_busy), .bank_sel(bank_sel),
  .any_valid(any_valid), .fill_we(fill_we), .swap_req(swap_req)
);

// File: tb/route_cache_bench.sv
module route_cache_bench;
  localparam int IDX_W = 6;
  localparam int LINES = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_dest = '0;
  logic        lk_ready, rsp_valid, rsp_hit, miss_busy, bank_sel;
  logic [63:0] rsp_route;
  logic [31:0] miss_dest;
  logic        refill_valid = 1'b0;
  logic [63:0] refill_route = '0;
  logic        swap_req = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        m_valid [LINES];
  logic [31:0] m_tag   [LINES];
  logic [63:0] m_route [LINES];
  logic        m_bank = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  route_cache #(.IDX_W(IDX_W)) u_route_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_dest(lk_dest),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_route(rsp_route), .miss_busy(miss_busy), .miss_dest(miss_dest),
    .refill_valid(refill_valid), .refill_route(refill_route),
    .swap_req(swap_req), .bank_sel(bank_sel)
  );

  // chunk-wise fold, written independently of the design
  function automatic logic [IDX_W-1:0] ref_idx(input logic [31:0] d);
    logic [31:0] acc;
    acc = '0;
    for (int k = 0; k < 32; k += IDX_W) acc = acc ^ (d >> k);
    return acc[IDX_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
  endtask

  // starts and ends just after a falling edge
  task automatic lookup(input logic [31:0] d, input string req);
    logic [IDX_W-1:0] ix;
    logic             eh;
    logic [63:0]      rt;
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1; lk_dest = d;
    @(negedge clk);
    lk_valid = 1'b0;
    ix = ref_idx(d);
    eh = m_valid[ix] && (m_tag[ix] == d);
    chk(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_hit == eh, req, "rsp_hit", 64'(rsp_hit), 64'(eh));
    if (eh) chk(rsp_route == m_route[ix], req, "rsp_route", rsp_route, m_route[ix]);
    if (!eh) begin
      rt = {$urandom, $urandom};
      @(negedge clk);
      chk(miss_busy == 1'b1, "R4", "miss_busy", 64'(miss_busy), 64'd1);
      chk(miss_dest == d, "R4", "miss_dest", 64'(miss_dest), 64'(d));
      chk(lk_ready == 1'b0, "R4", "lk_ready", 64'(lk_ready), 64'd0);
      refill_valid = 1'b1; refill_route = rt;
      @(negedge clk);
      refill_valid = 1'b0;
      chk(miss_busy == 1'b0, "R5", "miss_busy after refill", 64'(miss_busy), 64'd0);
      m_valid[ix] = 1'b1; m_tag[ix] = d; m_route[ix] = rt;
    end
  endtask

  task automatic do_swap();
    swap_req = 1'b1;
    #1;
    chk(lk_ready == 1'b0, "R8", "lk_ready during swap_req", 64'(lk_ready), 64'd0);
    @(negedge clk);
    swap_req = 1'b0;
    @(negedge clk);
    m_bank = ~m_bank;
    clear_model();
    chk(bank_sel == m_bank, "R6", "bank_sel", 64'(bank_sel), 64'(m_bank));
    chk(lk_ready == 1'b1, "R6", "lk_ready after swap", 64'(lk_ready), 64'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pool [24];
    logic [31:0] da, db, dc;
    logic [63:0] keep;
    void'($urandom(32'd20240611));
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(lk_ready == 1'b1, "R1", "lk_ready", 64'(lk_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk(miss_busy == 1'b0, "R1", "miss_busy", 64'(miss_busy), 64'd0);
    chk(bank_sel == 1'b0, "R1", "bank_sel", 64'(bank_sel), 64'd0);
    da = $urandom;
    lookup(da, "R1");          // must miss on an empty cache
    lookup(da, "R3");          // now hits

    // R2 aliasing: bits 0 and IDX_W fold onto the same index bit
    db = da ^ 32'h1 ^ (32'h1 << IDX_W);
    chk(ref_idx(db) == ref_idx(da), "R2", "alias index", 64'(ref_idx(db)), 64'(ref_idx(da)));
    lookup(db, "R2");          // miss, evicts da
    lookup(da, "R2");          // miss again
    lookup(db, "R2");          // evicted by da: miss

    // R5 stray refill is ignored
    keep = m_route[ref_idx(db)];
    refill_valid = 1'b1; refill_route = ~keep;
    @(negedge clk);
    refill_valid = 1'b0;
    chk(miss_busy == 1'b0, "R5", "stray refill miss_busy", 64'(miss_busy), 64'd0);
    lookup(db, "R5");          // still hits with old route

    // R9 back-to-back hits
    dc = db ^ 32'h2;
    lookup(dc, "R9");
    lk_valid = 1'b1; lk_dest = db;
    @(negedge clk);
    chk(rsp_hit == 1'b1, "R9", "first hit", 64'(rsp_hit), 64'd1);
    chk(lk_ready == 1'b1, "R9", "lk_ready between hits", 64'(lk_ready), 64'd1);
    lk_dest = dc;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid && rsp_hit, "R9", "second hit", 64'(rsp_hit), 64'd1);
    chk(rsp_route == m_route[ref_idx(dc)], "R9", "second route", rsp_route, m_route[ref_idx(dc)]);

    // R6 swap with a response still in flight, then flush seen
    do_swap();
    lookup(dc, "R6");          // miss after flush

    // R7 swap while a miss is pending
    da = $urandom;
    lk_valid = 1'b1; lk_dest = da;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_hit == 1'b0, "R7", "fresh miss", 64'(rsp_hit), 64'd0);
    @(negedge clk);
    chk(miss_busy == 1'b1, "R7", "miss pending", 64'(miss_busy), 64'd1);
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    m_bank = ~m_bank;
    clear_model();
    chk(miss_busy == 1'b0, "R7", "miss dropped", 64'(miss_busy), 64'd0);
    chk(bank_sel == m_bank, "R7", "bank_sel", 64'(bank_sel), 64'(m_bank));
    refill_valid = 1'b1; refill_route = {$urandom, $urandom};
    @(negedge clk);
    refill_valid = 1'b0;
    lookup(da, "R7");          // stale refill not written: miss

    // random mix
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 2) pool[i] = pool[i-1] ^ 32'h1 ^ (32'h1 << IDX_W);
      else            pool[i] = $urandom;
    end
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 39) == 0) do_swap();
      else lookup(pool[$urandom_range(0, 23)], "R3");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule